// File: doc/BRIEF.md
# Multi-core Boot Role Sequencer

This block brings a small group of cores out of reset and gives each one its boot role. A power-up reset or a low level on the external reset line starts one shared sequence. First, every present core gets a default-load strobe, which sets its architectural registers to known values and puts it in real-address execution mode. Next come three invalidation strobes, one each for the caches, the TLBs and the branch target buffer. The sequencer waits for an acknowledge of each kind. If the self-test enable is set, it then starts the built-in self-test on every present core and collects the results.

Once that preparation is complete, the block gives each core a role according to the mode select. In the elected mode, the lowest-numbered healthy core becomes the bootstrap core and every other healthy core waits for a startup message. In the fixed-primary mode, core 0 runs and core 1 is parked as a halted secondary. In the legacy mode, the first healthy core runs and no waiting cores are created. A waiting core starts running when a startup message addressed to it arrives, and it takes its start vector from that message.

Top module: `boot_role_ctrl`

## Requirements
- R1: While `rst` is high, or in the cycle after `ext_reset_n` is sampled low, every core shows state RESET (code 1) if its bit in `core_present` is set and ABSENT (code 0) otherwise. Every role is NONE (code 0), `fetch_en` is all zero, `start_vec` is zero and `boot_done` is low.
- R2: `arch_load` equals the latched present mask while reset is applied and for exactly one cycle after reset is released, and it is zero at every other time.
- R3: Each of `inv_cache_stb`, `inv_tlb_stb` and `inv_btb_stb` pulses for one cycle with the present mask, in the cycle after the `arch_load` pulse ends. No core gets `fetch_en` until all three done inputs have been seen, in any order and on any cycles.
- R4: When `bist_en` is set, `bist_start` pulses once with the present mask after invalidation, and roles are assigned only after `bist_done` has been seen for every present core. When `bist_en` is clear, `bist_start` never pulses.
- R5: With `boot_mode` 0 (elected mode), the lowest-numbered present core that passed self-test gets state RUN (code 2), role BSP (code 1), `fetch_en` high and `start_vec` equal to `RESET_VEC`. Every other healthy present core gets state WAIT (code 3) and role AP (code 2).
- R6: In elected mode with a single present core, that core becomes the bootstrap core, whatever its index.
- R7: A present core whose `bist_pass` was low when its `bist_done` was seen gets state HALT (code 4) and role NONE, and it is left out of the election.
- R8: With `boot_mode` 1 (fixed-primary mode), core 0 becomes the bootstrap core, core 1 gets state HALT and role SEC (code 3), and all higher cores are HALT with role NONE.
- R9: With `boot_mode` 2 or 3 (legacy mode), the lowest healthy present core runs as the bootstrap core, and every other core is HALT with role NONE. No core is set to WAIT.
- R10: A core in WAIT that sees its `sipi_valid` bit high while `boot_done` is high moves to RUN on the next cycle and latches `sipi_vector` into its `start_vec` slice. A message to a core in any other state changes neither its state nor its `start_vec`.
- R11: When a startup message and a low `ext_reset_n` arrive in the same cycle, the reset takes priority and the core returns to RESET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| ext_reset_n | input | 1 | Synchronous active-low external reset request |
| bist_en | input | 1 | Run self-test after invalidation |
| boot_mode | input | 2 | 0 elected, 1 fixed primary, 2/3 legacy |
| core_present | input | N | Cores fitted, latched during reset |
| inv_cache_done | input | 1 | Cache invalidation acknowledge |
| inv_tlb_done | input | 1 | TLB invalidation acknowledge |
| inv_btb_done | input | 1 | Branch target buffer invalidation acknowledge |
| bist_done | input | N | Per-core self-test finished |
| bist_pass | input | N | Per-core self-test result, valid with bist_done |
| sipi_valid | input | N | Per-core startup message strobe |
| sipi_vector | input | N*V | Per-core start vector carried by the message |
| arch_load | output | N | Load register defaults and real-address mode |
| inv_cache_stb | output | N | Cache invalidate strobe |
| inv_tlb_stb | output | N | TLB invalidate strobe |
| inv_btb_stb | output | N | Branch target buffer invalidate strobe |
| bist_start | output | N | Self-test start strobe |
| core_state | output | N*3 | Per-core state code |
| core_role | output | N*2 | Per-core role code |
| fetch_en | output | N | Per-core fetch enable |
| start_vec | output | N*V | Per-core start vector |
| boot_done | output | 1 | Role assignment complete |

## Verification
Two events can fall on the same clock edge: a startup message accepted by a waiting core, and a reset request that restarts the whole sequence. The bench raises the message and pulls the reset line low on the same falling edge. After the following rising edge, the targeted core must show RESET with a zero vector and no fetch enable, not RUN. A second overlap comes from the three invalidation acknowledges. The bench gives them on separate cycles and also in the same cycle, and checks that nothing fetches before the last one has been seen.

// File: rtl/boot_pkg.sv
package boot_pkg;

    typedef enum logic [2:0] {
        CS_ABSENT = 3'd0,
        CS_RESET  = 3'd1,
        CS_RUN    = 3'd2,
        CS_WAIT   = 3'd3,
        CS_HALT   = 3'd4
    } core_state_e;

    typedef enum logic [1:0] {
        ROLE_NONE = 2'd0,
        ROLE_BSP  = 2'd1,
        ROLE_AP   = 2'd2,
        ROLE_SEC  = 2'd3
    } core_role_e;

    typedef enum logic [1:0] {
        MODE_ELECT  = 2'd0,
        MODE_FIXED  = 2'd1,
        MODE_LEGACY = 2'd2,
        MODE_LEGALT = 2'd3
    } boot_mode_e;

    typedef enum logic [2:0] {
        SQ_LOAD,
        SQ_INV,
        SQ_INV_WAIT,
        SQ_BIST,
        SQ_BIST_WAIT,
        SQ_ELECT,
        SQ_DONE
    } seq_phase_e;

    typedef struct packed {
        core_state_e st;
        core_role_e  role;
    } slot_decision_t;

    localparam int STATE_W = 3;
    localparam int ROLE_W  = 2;

    function automatic logic is_legacy(boot_mode_e m);
        return (m == MODE_LEGACY) || (m == MODE_LEGALT);
    endfunction

endpackage

// File: rtl/boot_seq.sv
module boot_seq
    import boot_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_any,
    input  logic [N-1:0] core_present,
    input  logic [1:0]   boot_mode,
    input  logic         bist_en,
    input  logic         inv_cache_done,
    input  logic         inv_tlb_done,
    input  logic         inv_btb_done,
    input  logic [N-1:0] bist_done,
    input  logic [N-1:0] bist_pass,
    output seq_phase_e   phase,
    output logic [N-1:0] present_q,
    output boot_mode_e   mode_q,
    output logic [N-1:0] health_ok
);

    localparam int INV_KINDS = 3;

    logic [INV_KINDS-1:0] inv_seen, inv_now;
    logic [N-1:0]         done_seen, pass_seen, done_now, pass_now;
    logic                 bist_ran;

    assign inv_now  = inv_seen | {inv_btb_done, inv_tlb_done, inv_cache_done};
    assign done_now = done_seen | (bist_done & present_q);
    assign pass_now = pass_seen | (bist_done & bist_pass & present_q);
    assign health_ok = bist_ran ? pass_seen : {N{1'b1}};

    always_ff @(posedge clk) begin
        if (rst_any) begin
            phase     <= SQ_LOAD;
            present_q <= core_present;
            mode_q    <= boot_mode_e'(boot_mode);
            inv_seen  <= '0;
            done_seen <= '0;
            pass_seen <= '0;
            bist_ran  <= 1'b0;
        end else begin
            case (phase)
                SQ_LOAD:  phase <= SQ_INV;
                SQ_INV:   phase <= SQ_INV_WAIT;
                SQ_INV_WAIT: begin
                    inv_seen <= inv_now;
                    if (&inv_now) begin
                        bist_ran <= bist_en;
                        phase    <= bist_en ? SQ_BIST : SQ_ELECT;
                    end
                end
                SQ_BIST:  phase <= SQ_BIST_WAIT;
                SQ_BIST_WAIT: begin
                    done_seen <= done_now;
                    pass_seen <= pass_now;
                    if (done_now == present_q) phase <= SQ_ELECT;
                end
                SQ_ELECT: phase <= SQ_DONE;
                default:  phase <= SQ_DONE;
            endcase
        end
    end

endmodule

// File: rtl/boot_elect.sv
module boot_elect
    import boot_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                     [N-1:0] present,
    input  logic                     [N-1:0] health_ok,
    input  boot_mode_e                       mode,
    output slot_decision_t           [N-1:0] dec
);

    logic [N-1:0] eligible, winner;

    assign eligible = present & health_ok;
    // isolate lowest set bit: fixed priority toward core 0
    assign winner   = eligible & (~eligible + {{(N-1){1'b0}}, 1'b1});

    for (genvar g = 0; g < N; g++) begin : g_core
        always_comb begin
            dec[g].st   = CS_HALT;
            dec[g].role = ROLE_NONE;
            if (!present[g]) begin
                dec[g].st = CS_ABSENT;
            end else if (!health_ok[g]) begin
                dec[g].st = CS_HALT;
            end else if (mode == MODE_ELECT) begin
                dec[g].st   = winner[g] ? CS_RUN : CS_WAIT;
                dec[g].role = winner[g] ? ROLE_BSP : ROLE_AP;
            end else if (mode == MODE_FIXED) begin
                if (g == 0) begin
                    dec[g].st   = CS_RUN;
                    dec[g].role = ROLE_BSP;
                end else if (g == 1) begin
                    dec[g].role = ROLE_SEC;
                end
            end else if (is_legacy(mode) && winner[g]) begin
                dec[g].st   = CS_RUN;
                dec[g].role = ROLE_BSP;
            end
        end
    end

endmodule

// File: rtl/boot_slot.sv
module boot_slot
    import boot_pkg::*;
#(
    parameter int             V         = 8,
    parameter logic [V-1:0]   RESET_VEC = 8'hF0
) (
    input  logic           clk,
    input  logic           rst_any,
    input  logic           present_now,
    input  logic           load,
    input  slot_decision_t dec,
    input  logic           done,
    input  logic           sipi_valid,
    input  logic [V-1:0]   sipi_vector,
    output core_state_e    st,
    output core_role_e     role,
    output logic [V-1:0]   vec,
    output logic           fetch_en
);

    always_ff @(posedge clk) begin
        if (rst_any) begin
            st   <= present_now ? CS_RESET : CS_ABSENT;
            role <= ROLE_NONE;
            vec  <= '0;
        end else if (load) begin
            st   <= dec.st;
            role <= dec.role;
            vec  <= (dec.role == ROLE_BSP) ? RESET_VEC : '0;
        end else if (done && st == CS_WAIT && sipi_valid) begin
            st  <= CS_RUN;
            vec <= sipi_vector;
        end
    end

    assign fetch_en = (st == CS_RUN);

endmodule

// File: rtl/boot_role_ctrl.sv
module boot_role_ctrl
    import boot_pkg::*;
#(
    parameter int           N         = 4,
    parameter int           V         = 8,
    parameter logic [V-1:0] RESET_VEC = 8'hF0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_reset_n,
    input  logic             bist_en,
    input  logic [1:0]       boot_mode,
    input  logic [N-1:0]     core_present,
    input  logic             inv_cache_done,
    input  logic             inv_tlb_done,
    input  logic             inv_btb_done,
    input  logic [N-1:0]     bist_done,
    input  logic [N-1:0]     bist_pass,
    input  logic [N-1:0]     sipi_valid,
    input  logic [N*V-1:0]   sipi_vector,
    output logic [N-1:0]     arch_load,
    output logic [N-1:0]     inv_cache_stb,
    output logic [N-1:0]     inv_tlb_stb,
    output logic [N-1:0]     inv_btb_stb,
    output logic [N-1:0]     bist_start,
    output logic [N*3-1:0]   core_state,
    output logic [N*2-1:0]   core_role,
    output logic [N-1:0]     fetch_en,
    output logic [N*V-1:0]   start_vec,
    output logic             boot_done
);

    logic                    rst_any;
    seq_phase_e              phase;
    logic [N-1:0]            present_q, health_ok;
    boot_mode_e              mode_q;
    slot_decision_t [N-1:0]  dec;

    assign rst_any = rst | ~ext_reset_n;

    boot_seq #(.N(N)) i_seq (
        .clk            (clk),
        .rst_any        (rst_any),
        .core_present   (core_present),
        .boot_mode      (boot_mode),
        .bist_en        (bist_en),
        .inv_cache_done (inv_cache_done),
        .inv_tlb_done   (inv_tlb_done),
        .inv_btb_done   (inv_btb_done),
        .bist_done      (bist_done),
        .bist_pass      (bist_pass),
        .phase          (phase),
        .present_q      (present_q),
        .mode_q         (mode_q),
        .health_ok      (health_ok)
    );

    boot_elect #(.N(N)) i_elect (
        .present   (present_q),
        .health_ok (health_ok),
        .mode      (mode_q),
        .dec       (dec)
    );

    assign arch_load     = (phase == SQ_LOAD) ? present_q : '0;
    assign inv_cache_stb = (phase == SQ_INV)  ? present_q : '0;
    assign inv_tlb_stb   = (phase == SQ_INV)  ? present_q : '0;
    assign inv_btb_stb   = (phase == SQ_INV)  ? present_q : '0;
    assign bist_start    = (phase == SQ_BIST) ? present_q : '0;
    assign boot_done     = (phase == SQ_DONE);

    for (genvar g = 0; g < N; g++) begin : g_slot
        core_state_e st;
        core_role_e  role;

        boot_slot #(.V(V), .RESET_VEC(RESET_VEC)) i_slot (
            .clk         (clk),
            .rst_any     (rst_any),
            .present_now (core_present[g]),
            .load        (phase == SQ_ELECT),
            .dec         (dec[g]),
            .done        (phase == SQ_DONE),
            .sipi_valid  (sipi_valid[g]),
            .sipi_vector (sipi_vector[g*V +: V]),
            .st          (st),
            .role        (role),
            .vec         (start_vec[g*V +: V]),
            .fetch_en    (fetch_en[g])
        );

        assign core_state[g*STATE_W +: STATE_W] = st;
        assign core_role[g*ROLE_W +: ROLE_W]    = role;
    end

endmodule

// File: rtl/boot_role_chk.sv
module boot_role_chk #(
    parameter int N = 4,
    parameter int V = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           ext_reset_n,
    input logic           bist_en,
    input logic [N-1:0]   arch_load,
    input logic [N-1:0]   inv_cache_stb,
    input logic [N-1:0]   inv_tlb_stb,
    input logic [N-1:0]   inv_btb_stb,
    input logic [N-1:0]   bist_start,
    input logic [N*3-1:0] core_state,
    input logic [N*2-1:0] core_role,
    input logic [N-1:0]   fetch_en,
    input logic [N*V-1:0] start_vec,
    input logic           boot_done
);

    logic [N-1:0] bsp_mask;
    for (genvar g = 0; g < N; g++) begin : g_bsp
        assign bsp_mask[g] = (core_role[g*2 +: 2] == 2'd1);
    end

    assert_load_not_done_R2: assert property (@(posedge clk) disable iff (rst || !ext_reset_n)
        (|arch_load) |-> !boot_done);

    assert_inv_pulse_R3: assert property (@(posedge clk) disable iff (rst || !ext_reset_n)
        (|(inv_cache_stb | inv_tlb_stb | inv_btb_stb)) |=> !(|(inv_cache_stb | inv_tlb_stb | inv_btb_stb)));

    assert_fetch_gated_R3: assert property (@(posedge clk) disable iff (rst || !ext_reset_n)
        (|fetch_en) |-> boot_done);

    assert_bist_gate_R4: assert property (@(posedge clk) disable iff (rst || !ext_reset_n)
        (|bist_start) |-> bist_en);

    assert_single_bsp_R5: assert property (@(posedge clk) disable iff (rst || !ext_reset_n)
        boot_done |-> ($countones(bsp_mask) <= 1));

    for (genvar g = 0; g < N; g++) begin : g_core
        assert_run_holds_R10: assert property (@(posedge clk) disable iff (rst || !ext_reset_n)
            (boot_done && core_state[g*3 +: 3] == 3'd2) |=> (core_state[g*3 +: 3] == 3'd2));
        assert_vec_stable_R10: assert property (@(posedge clk) disable iff (rst || !ext_reset_n)
            (boot_done && core_state[g*3 +: 3] == 3'd2) |=> $stable(start_vec[g*V +: V]));
    end

endmodule

bind boot_role_ctrl boot_role_chk #(.N(N), .V(V)) i_boot_role_chk (
    .clk           (clk),
    .rst           (rst),
    .ext_reset_n   (ext_reset_n),
    .bist_en       (bist_en),
    .arch_load     (arch_load),
    .inv_cache_stb (inv_cache_stb),
    .inv_tlb_stb   (inv_tlb_stb),
    .inv_btb_stb   (inv_btb_stb),
    .bist_start    (bist_start),
    .core_state    (core_state),
    .core_role     (core_role),
    .fetch_en      (fetch_en),
    .start_vec     (start_vec),
    .boot_done     (boot_done)
);

// File: tb/test_boot_role_ctrl.sv
module test_boot_role_ctrl;

    localparam int N = 4;
    localparam int V = 8;
    localparam logic [V-1:0] RVEC = 8'hF0;

    localparam logic [2:0] S_ABS = 3'd0, S_RST = 3'd1, S_RUN = 3'd2, S_WAIT = 3'd3, S_HALT = 3'd4;
    localparam logic [1:0] R_NONE = 2'd0, R_BSP = 2'd1, R_AP = 2'd2, R_SEC = 2'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_reset_n = 1'b1;
    logic bist_en = 1'b0;
    logic [1:0] boot_mode = 2'd0;
    logic [N-1:0] core_present = '1;
    logic inv_cache_done = 1'b0, inv_tlb_done = 1'b0, inv_btb_done = 1'b0;
    logic [N-1:0] bist_done = '0, bist_pass = '0, sipi_valid = '0;
    logic [N*V-1:0] sipi_vector = '0;
    logic [N-1:0] arch_load, inv_cache_stb, inv_tlb_stb, inv_btb_stb, bist_start, fetch_en;
    logic [N*3-1:0] core_state;
    logic [N*2-1:0] core_role;
    logic [N*V-1:0] start_vec;
    logic boot_done;

    int n_checks = 0;
    int n_fail = 0;
    int bist_pulses = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    boot_role_ctrl #(.N(N), .V(V), .RESET_VEC(RVEC)) i_boot_role_ctrl (
        .clk(clk), .rst(rst), .ext_reset_n(ext_reset_n), .bist_en(bist_en),
        .boot_mode(boot_mode), .core_present(core_present),
        .inv_cache_done(inv_cache_done), .inv_tlb_done(inv_tlb_done), .inv_btb_done(inv_btb_done),
        .bist_done(bist_done), .bist_pass(bist_pass), .sipi_valid(sipi_valid),
        .sipi_vector(sipi_vector), .arch_load(arch_load), .inv_cache_stb(inv_cache_stb),
        .inv_tlb_stb(inv_tlb_stb), .inv_btb_stb(inv_btb_stb), .bist_start(bist_start),
        .core_state(core_state), .core_role(core_role), .fetch_en(fetch_en),
        .start_vec(start_vec), .boot_done(boot_done)
    );

    always @(negedge clk) if (|bist_start) bist_pulses++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cycles);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_core(input int c, input logic [2:0] st, input logic [1:0] rl,
                            input logic [V-1:0] vec, input string req);
        chk(core_state[c*3 +: 3] == st, req, core_state[c*3 +: 3], st);
        chk(core_role[c*2 +: 2] == rl, req, core_role[c*2 +: 2], rl);
        chk(start_vec[c*V +: V] == vec, req, start_vec[c*V +: V], vec);
        chk(fetch_en[c] == (st == S_RUN), req, fetch_en[c], st == S_RUN);
    endtask

    // restart the sequence and drive it to role assignment
    task automatic boot(input logic [1:0] mode, input logic [N-1:0] pres,
                        input bit use_bist, input logic [N-1:0] pass, input bit acks_together);
        @(negedge clk);
        boot_mode = mode; core_present = pres; bist_en = use_bist;
        ext_reset_n = 1'b0;
        bist_pulses = 0;
        @(negedge clk);
        for (int c = 0; c < N; c++)
            chk(core_state[c*3 +: 3] == (pres[c] ? S_RST : S_ABS), "R1 reset state",
                core_state[c*3 +: 3], pres[c] ? S_RST : S_ABS);
        chk(!boot_done && fetch_en == 0 && start_vec == 0 && core_role == 0, "R1 outputs idle",
            {boot_done, fetch_en}, 0);
        chk(arch_load == pres, "R2 load during reset", arch_load, pres);
        ext_reset_n = 1'b1;
        @(negedge clk);
        chk(arch_load == 0, "R2 load pulse ends", arch_load, 0);
        chk(inv_cache_stb == pres && inv_tlb_stb == pres && inv_btb_stb == pres, "R3 strobes",
            inv_cache_stb, pres);
        @(negedge clk);
        chk((inv_cache_stb | inv_tlb_stb | inv_btb_stb) == 0, "R3 strobe one cycle",
            inv_cache_stb, 0);
        if (acks_together) begin
            inv_cache_done = 1; inv_tlb_done = 1; inv_btb_done = 1;
            @(negedge clk);
            inv_cache_done = 0; inv_tlb_done = 0; inv_btb_done = 0;
        end else begin
            inv_cache_done = 1;
            @(negedge clk);
            inv_cache_done = 0; inv_tlb_done = 1;
            @(negedge clk);
            inv_tlb_done = 0;
            repeat (3) @(negedge clk);
            chk(!boot_done && fetch_en == 0, "R3 no fetch before all acks", fetch_en, 0);
            inv_btb_done = 1;
            @(negedge clk);
            inv_btb_done = 0;
        end
        if (use_bist) begin
            for (int k = 0; k < 10; k++) begin
                if (|bist_start) break;
                @(negedge clk);
            end
            chk(bist_start == pres, "R4 self-test start", bist_start, pres);
            @(negedge clk);
            bist_done = pres & 4'b0011; bist_pass = pass;
            @(negedge clk);
            bist_done = '0;
            repeat (2) @(negedge clk);
            chk(pres[3:2] == 0 || !boot_done, "R4 waits for all done", boot_done, 0);
            bist_done = pres & 4'b1100;
            @(negedge clk);
            bist_done = '0; bist_pass = '0;
        end
        for (int k = 0; k < 10; k++) begin
            if (boot_done) break;
            @(negedge clk);
        end
        chk(boot_done, "R3 sequence completes", boot_done, 1);
        chk(bist_pulses == (use_bist ? 1 : 0), "R4 self-test pulse count", bist_pulses, use_bist);
    endtask

    task automatic send_msg(input int c, input logic [V-1:0] v);
        @(negedge clk);
        sipi_valid[c] = 1'b1;
        sipi_vector[c*V +: V] = v;
        @(negedge clk);
        sipi_valid = '0;
    endtask

    task automatic t_power_up();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        for (int c = 0; c < N; c++) chk_core(c, S_RST, R_NONE, 0, "R1 power-up");
        chk(!boot_done, "R1 power-up not done", boot_done, 0);
        rst = 1'b0;
    endtask

    task automatic t_elect_all();
        boot(2'd0, 4'b1111, 0, '0, 0);
        chk_core(0, S_RUN, R_BSP, RVEC, "R5 lowest becomes bootstrap");
        for (int c = 1; c < N; c++) chk_core(c, S_WAIT, R_AP, 0, "R5 others wait");
    endtask

    task automatic t_messages();
        send_msg(2, 8'h3C);
        chk_core(2, S_RUN, R_AP, 8'h3C, "R10 waiting core starts");
        send_msg(2, 8'h77);
        chk_core(2, S_RUN, R_AP, 8'h3C, "R10 running core ignores message");
        send_msg(0, 8'h55);
        chk_core(0, S_RUN, R_BSP, RVEC, "R10 bootstrap ignores message");
        chk_core(1, S_WAIT, R_AP, 0, "R10 other core untouched");
    endtask

    task automatic t_bist_fail();
        boot(2'd0, 4'b1100, 1, 4'b1000, 1);
        chk_core(0, S_ABS, R_NONE, 0, "R7 absent core");
        chk_core(1, S_ABS, R_NONE, 0, "R7 absent core");
        chk_core(2, S_HALT, R_NONE, 0, "R7 failed core halted");
        chk_core(3, S_RUN, R_BSP, RVEC, "R7 next healthy core elected");
    endtask

    task automatic t_single();
        boot(2'd0, 4'b0100, 0, '0, 1);
        chk_core(2, S_RUN, R_BSP, RVEC, "R6 sole core bootstrap");
        chk(fetch_en == 4'b0100, "R6 only sole core fetches", fetch_en, 4'b0100);
    endtask

    task automatic t_fixed();
        boot(2'd1, 4'b1111, 0, '0, 0);
        chk_core(0, S_RUN, R_BSP, RVEC, "R8 primary runs");
        chk_core(1, S_HALT, R_SEC, 0, "R8 secondary halted");
        chk_core(2, S_HALT, R_NONE, 0, "R8 extra core halted");
        chk_core(3, S_HALT, R_NONE, 0, "R8 extra core halted");
        send_msg(1, 8'h21);
        chk_core(1, S_HALT, R_SEC, 0, "R10 halted core ignores message");
    endtask

    task automatic t_legacy();
        boot(2'd2, 4'b0110, 0, '0, 1);
        chk_core(0, S_ABS, R_NONE, 0, "R9 absent core");
        chk_core(1, S_RUN, R_BSP, RVEC, "R9 first core runs");
        chk_core(2, S_HALT, R_NONE, 0, "R9 no waiting core");
        boot(2'd3, 4'b1111, 1, 4'b1110, 1);
        chk_core(0, S_HALT, R_NONE, 0, "R9 failed core halted");
        chk_core(1, S_RUN, R_BSP, RVEC, "R9 next healthy runs");
        chk_core(3, S_HALT, R_NONE, 0, "R9 no waiting core");
    endtask

    task automatic t_collision();
        boot(2'd0, 4'b1111, 0, '0, 1);
        @(negedge clk);
        sipi_valid[1] = 1'b1;
        sipi_vector[1*V +: V] = 8'h99;
        ext_reset_n = 1'b0;
        @(negedge clk);
        sipi_valid = '0;
        ext_reset_n = 1'b1;
        chk_core(1, S_RST, R_NONE, 0, "R11 reset wins over message");
        chk(!boot_done, "R11 sequence restarted", boot_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_power_up();
        t_elect_all();
        t_messages();
        t_bist_fail();
        t_single();
        t_fixed();
        t_legacy();
        t_collision();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule